// File: doc/BRIEF.md
# Receive Squelch Timing Qualifier

This block sits behind the receive comparators of a 10BASE-T twisted-pair front end. It decides when real packet data, and not impulse noise, is arriving. It watches four comparator flags that are already synchronized to the system clock: a positive and a negative flag at the full squelch level, and a positive and a negative flag at a lower level. A rising edge of a flag counts as a threshold crossing.

In the idle state, only a crossing of a full-level flag can begin qualification, and that crossing may have either polarity. The opposite polarity must then cross within one timing window, and the starting polarity must cross again within a further window. When both happen, the block raises its data-valid output and switches its threshold-select output so that the lower levels are used. Once no reduced-level crossing has been seen for longer than one window, the block declares end of packet. It then drops data-valid, returns to the full levels and issues a one-cycle end-of-packet strobe.

The window length is a parameter in clock cycles. By default it is derived from a 100 MHz clock and a 150 ns window, which gives 15 cycles.

Top module: `squelch_qualifier`

## Requirements
- R1: While reset is high, and on the first cycle after it, `dataValid`, `useReduced` and `eopStrobe` are all 0.
- R2: While data is not valid, rising edges on `posRed` or `negRed` alone never assert `dataValid`.
- R3: The opposite-polarity full crossing must occur at most WIN_CYCLES clock edges after the first crossing. A gap of WIN_CYCLES edges is accepted. A gap of WIN_CYCLES+1 edges abandons the attempt.
- R4: The second crossing of the starting polarity must occur at most WIN_CYCLES edges after the opposite crossing. `dataValid` goes high on the clock edge that samples it. A gap of WIN_CYCLES+1 edges does not assert `dataValid`.
- R5: Qualification works the same way whether it starts with `posFull` or with `negFull`.
- R6: `useReduced` equals `dataValid` at all times. While data is valid, every rising edge on `posRed` or `negRed` restarts the quiet interval.
- R7: After the last reduced-level crossing (or the qualifying crossing), `dataValid` stays high for WIN_CYCLES more edges. It falls on edge WIN_CYCLES+1 if no crossing has occurred.
- R8: `eopStrobe` is high for exactly one cycle, on the same edge at which `dataValid` falls, and at no other time.
- R9: After an abandoned attempt the sequencer is idle, and the next full crossing begins a new attempt. A repeated crossing of the starting polarity while the sequencer waits for the opposite polarity does not restart the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| posFull | input | 1 | Positive full-level threshold exceeded |
| negFull | input | 1 | Negative full-level threshold exceeded |
| posRed | input | 1 | Positive reduced-level threshold exceeded |
| negRed | input | 1 | Negative reduced-level threshold exceeded |
| dataValid | output | 1 | Valid receive data present |
| useReduced | output | 1 | Threshold select: 1 selects the reduced levels |
| eopStrobe | output | 1 | One-cycle end-of-packet pulse |

## Verification
The assertions check the following on every cycle:
- the reset state;
- the pairing of `eopStrobe` with the fall of `dataValid`, including its one-cycle width;
- that `dataValid` can only rise after a full-level flag was high on the previous edge.

The window arithmetic can only be shown by the bench's scenarios. This covers accept at exactly WIN_CYCLES edges against reject at WIN_CYCLES+1 in both steps. It also covers a restart on the crossing that follows an abandoned attempt, and the refusal to restart on a same-polarity repeat. The quiet interval that reduced-level crossings keep extending is likewise shown only by those scenarios.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE      = 2'd0,
    SQ_WAIT_OPP  = 2'd1,
    SQ_WAIT_ORIG = 2'd2
  } sqState_t;

  // control -> datapath
  typedef struct packed {
    logic winClear;
    logic winInc;
    logic polLatch;
  } sqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic evStart;
    logic evOrig;
    logic evOpp;
    logic evRedAny;
    logic winDone;
    logic quietDone;
  } sqFlags_t;

endpackage

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
#(
  parameter int WIN_CYCLES = 15,
  parameter int CW = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      posFull,
  input  logic      negFull,
  input  logic      posRed,
  input  logic      negRed,
  input  sqStrobe_t strobe,
  output sqFlags_t  flags
);

  localparam int NFLAG = 4;
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYCLES - 1);
  localparam logic [CW-1:0] WIN_FULL = CW'(WIN_CYCLES);

  logic [NFLAG-1:0] levelNow;
  logic [NFLAG-1:0] levelPrev;
  logic [NFLAG-1:0] riseVec;
  logic [CW-1:0]    gapCnt;
  logic             startNeg;   // 1: attempt began on the negative side

  assign levelNow = {negRed, posRed, negFull, posFull};

  always_ff @(posedge clk) begin
    if (rst) levelPrev <= '0;
    else     levelPrev <= levelNow;
  end

  // one rising-edge detector per comparator flag
  for (genvar gi = 0; gi < NFLAG; gi++) begin : gRise
    assign riseVec[gi] = levelNow[gi] & ~levelPrev[gi];
  end

  // shared gap counter: window timing while qualifying, quiet timing while valid
  always_ff @(posedge clk) begin
    if (rst)                                gapCnt <= '0;
    else if (strobe.winClear)               gapCnt <= '0;
    else if (strobe.winInc && gapCnt != WIN_FULL) gapCnt <= gapCnt + 1'b1;
  end

  // positive wins a tie between simultaneous starts
  always_ff @(posedge clk) begin
    if (rst)                  startNeg <= 1'b0;
    else if (strobe.polLatch) startNeg <= ~riseVec[0];
  end

  always_comb begin
    flags.evStart   = riseVec[0] | riseVec[1];
    flags.evOrig    = startNeg ? riseVec[1] : riseVec[0];
    flags.evOpp     = startNeg ? riseVec[0] : riseVec[1];
    flags.evRedAny  = riseVec[2] | riseVec[3];
    flags.winDone   = (gapCnt == WIN_LAST);
    flags.quietDone = (gapCnt == WIN_FULL);
  end

endmodule

// File: rtl/sq_control.sv
module sq_control
  import sq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sqFlags_t  flags,
  output sqStrobe_t strobe,
  output logic      dataValid,
  output logic      eopStrobe
);

  sqState_t state, stateNext;
  logic     validQ, eopQ;
  logic     validSet, validClr;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    validSet  = 1'b0;
    validClr  = 1'b0;
    if (validQ) begin
      if (flags.evRedAny)       strobe.winClear = 1'b1;
      else if (flags.quietDone) validClr = 1'b1;
      else                      strobe.winInc = 1'b1;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (flags.evStart) begin
            stateNext       = SQ_WAIT_OPP;
            strobe.winClear = 1'b1;
            strobe.polLatch = 1'b1;
          end
        end
        SQ_WAIT_OPP: begin
          if (flags.evOpp) begin
            stateNext       = SQ_WAIT_ORIG;
            strobe.winClear = 1'b1;
          end else if (flags.winDone) begin
            stateNext = SQ_IDLE;
          end else begin
            strobe.winInc = 1'b1;
          end
        end
        SQ_WAIT_ORIG: begin
          if (flags.evOrig) begin
            stateNext       = SQ_IDLE;
            validSet        = 1'b1;
            strobe.winClear = 1'b1;
          end else if (flags.winDone) begin
            stateNext = SQ_IDLE;
          end else begin
            strobe.winInc = 1'b1;
          end
        end
        default: stateNext = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      validQ <= 1'b0;
      eopQ   <= 1'b0;
    end else begin
      state <= stateNext;
      eopQ  <= validClr;
      if (validSet)      validQ <= 1'b1;
      else if (validClr) validQ <= 1'b0;
    end
  end

  assign dataValid = validQ;
  assign eopStrobe = eopQ;

endmodule

// File: rtl/squelch_qualifier.sv
module squelch_qualifier
  import sq_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int WINDOW_NS  = 150,
  parameter int WIN_CYCLES = (CLK_MHZ * WINDOW_NS) / 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic posFull,
  input  logic negFull,
  input  logic posRed,
  input  logic negRed,
  output logic dataValid,
  output logic useReduced,
  output logic eopStrobe
);

  localparam int CW = $clog2(WIN_CYCLES + 1);

  sqStrobe_t strobe;
  sqFlags_t  flags;
  logic      validInt;

  sq_datapath #(.WIN_CYCLES(WIN_CYCLES), .CW(CW)) uDp (
    .clk     (clk),
    .rst     (rst),
    .posFull (posFull),
    .negFull (negFull),
    .posRed  (posRed),
    .negRed  (negRed),
    .strobe  (strobe),
    .flags   (flags)
  );

  sq_control uCtl (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags),
    .strobe    (strobe),
    .dataValid (validInt),
    .eopStrobe (eopStrobe)
  );

  assign dataValid  = validInt;
  assign useReduced = validInt;

endmodule

// File: rtl/sq_checker.sv
module sq_checker (
  input logic clk,
  input logic rst,
  input logic posFull,
  input logic negFull,
  input logic dataValid,
  input logic useReduced,
  input logic eopStrobe
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!dataValid && !useReduced && !eopStrobe)); // R1

  AST_RISE_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(dataValid)) |-> $past(posFull || negFull)); // R4

  AST_EOP_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    eopStrobe |-> $fell(dataValid)); // R8

  AST_FALL_HAS_EOP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(dataValid)) |-> eopStrobe); // R8

  AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eopStrobe |=> !eopStrobe); // R8

  AST_SELECT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $changed(useReduced)) |-> $changed(dataValid)); // R6

endmodule

bind squelch_qualifier sq_checker uChk (
  .clk        (clk),
  .rst        (rst),
  .posFull    (posFull),
  .negFull    (negFull),
  .dataValid  (dataValid),
  .useReduced (useReduced),
  .eopStrobe  (eopStrobe)
);

// File: tb/tb_squelch_qualifier.sv
module tb_squelch_qualifier;

  localparam int WIN = 15;
  localparam int K_NONE = 0, K_POS = 1, K_NEG = 2, K_RPOS = 3, K_RNEG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic posFull = 1'b0, negFull = 1'b0, posRed = 1'b0, negRed = 1'b0;
  logic dataValid, useReduced, eopStrobe;

  squelch_qualifier dut (
    .clk(clk), .rst(rst),
    .posFull(posFull), .negFull(negFull), .posRed(posRed), .negRed(negRed),
    .dataValid(dataValid), .useReduced(useReduced), .eopStrobe(eopStrobe)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  v;
    logic  e;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic checkNow(string tag, logic v, logic e);
    checks++;
    if (dataValid !== v || useReduced !== v || eopStrobe !== e) begin
      fails++;
      $display("FAIL %s cyc=%0d actual valid=%b sel=%b eop=%b expected valid=%b sel=%b eop=%b",
               tag, cyc, dataValid, useReduced, eopStrobe, v, v, e);
    end
  endtask

  task automatic expectAt(int at, logic v, logic e, string tag);
    expItem_t it;
    it.at = at; it.v = v; it.e = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: pops expectations due in this cycle
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].at <= cyc) begin
        checkNow(expQ[i].tag, expQ[i].v, expQ[i].e);
        expQ.delete(i);
      end
    end
  end

  // drive one cycle of inputs; returns the clock edge that samples them
  task automatic drv(int kind, output int edgeNum);
    @(negedge clk);
    posFull = (kind == K_POS);
    negFull = (kind == K_NEG);
    posRed  = (kind == K_POS) || (kind == K_RPOS);
    negRed  = (kind == K_NEG) || (kind == K_RNEG);
    edgeNum = cyc + 1;
  endtask

  task automatic gapThen(int gap, int kind, output int edgeNum);
    int dummy;
    for (int i = 0; i < gap; i++) drv(K_NONE, dummy);
    drv(kind, edgeNum);
  endtask

  task automatic quiet(int n);
    int dummy;
    for (int i = 0; i < n; i++) drv(K_NONE, dummy);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int e0, e1, e2, e3, eL;
    // R1: reset state
    repeat (3) @(negedge clk);
    checkNow("R1 in reset", 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    checkNow("R1 after reset", 1'b0, 1'b0);
    quiet(3);

    // R4/R7/R8: positive start, short gaps, then silence
    gapThen(0, K_POS, e0);
    gapThen(4, K_NEG, e1);
    gapThen(4, K_POS, e2);
    checkNow("R4 before final crossing", 1'b0, 1'b0);
    expectAt(e2, 1'b1, 1'b0, "R4 accept");
    expectAt(e2 + WIN, 1'b1, 1'b0, "R7 still valid");
    expectAt(e2 + WIN + 1, 1'b0, 1'b1, "R7 R8 end of packet");
    expectAt(e2 + WIN + 2, 1'b0, 1'b0, "R8 strobe one cycle");
    quiet(40);

    // R3/R5: negative start, both gaps exactly WIN edges
    gapThen(0, K_NEG, e0);
    gapThen(WIN - 1, K_POS, e1);
    gapThen(WIN - 1, K_NEG, e2);
    expectAt(e2, 1'b1, 1'b0, "R3 R5 accept at window edge");
    quiet(40);

    // R3/R9: opposite after WIN+1 edges abandons; that crossing starts anew
    gapThen(0, K_POS, e0);
    gapThen(WIN, K_NEG, e1);
    gapThen(2, K_POS, e2);
    expectAt(e2, 1'b0, 1'b0, "R3 late opposite rejected");
    gapThen(2, K_NEG, e3);
    expectAt(e3, 1'b1, 1'b0, "R9 restart qualifies");
    quiet(40);

    // R4: original polarity after WIN+1 edges rejected
    gapThen(0, K_POS, e0);
    gapThen(2, K_NEG, e1);
    gapThen(WIN, K_POS, e2);
    expectAt(e2, 1'b0, 1'b0, "R4 late original rejected");
    expectAt(e2 + 1, 1'b0, 1'b0, "R4 late original rejected");
    quiet(40);
    checkNow("R4 no valid after timeout", 1'b0, 1'b0);

    // R9: same-polarity repeat does not restart the window
    gapThen(0, K_POS, e0);
    gapThen(4, K_POS, e1);
    gapThen(11, K_NEG, e2);
    gapThen(2, K_POS, e3);
    expectAt(e3, 1'b0, 1'b0, "R9 repeat ignored");
    expectAt(e3 + 1, 1'b0, 1'b0, "R9 repeat ignored");
    quiet(40);

    // R2: reduced-only activity while idle
    gapThen(0, K_RPOS, e0);
    gapThen(2, K_RNEG, e1);
    gapThen(2, K_RPOS, e2);
    gapThen(2, K_RNEG, e3);
    expectAt(e2, 1'b0, 1'b0, "R2 reduced ignored");
    expectAt(e3, 1'b0, 1'b0, "R2 reduced ignored");
    quiet(10);
    checkNow("R2 reduced ignored", 1'b0, 1'b0);
    quiet(20);

    // R6/R7: reduced crossings keep data valid
    gapThen(0, K_POS, e0);
    gapThen(3, K_NEG, e1);
    gapThen(3, K_POS, e2);
    expectAt(e2, 1'b1, 1'b0, "R6 accept");
    gapThen(9, K_RPOS, eL);
    gapThen(9, K_RNEG, eL);
    gapThen(9, K_RPOS, eL);
    gapThen(9, K_RNEG, eL);
    expectAt(eL + WIN, 1'b1, 1'b0, "R6 R7 held by reduced crossings");
    expectAt(eL + WIN + 1, 1'b0, 1'b1, "R7 R8 end after last crossing");
    expectAt(eL + WIN + 2, 1'b0, 1'b0, "R8 strobe one cycle");
    quiet(40);

    checkNow("R1 idle at end", 1'b0, 1'b0);
    quiet(3);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1 pending expectations actual=%0d expected=0", expQ.size());
    end
    finishRun();
  end

endmodule